// File: doc/BRIEF.md
# BCD Time-Calendar Counter Chain

This block keeps wall-clock time and calendar date as five cascaded packed-BCD counters: seconds, minutes, hours, day of month and month. An external prescaler supplies a single-cycle enable once per second, and a run input gates whether that enable advances the chain. Each counter carries into the next when it wraps. The day counter's last value follows the current month, and a leap flag decides how long February is.

Software-visible mode bits live inside the counter bytes themselves. The hours byte holds a 12/24-hour select and a meridian flag next to the hour value. The month byte holds a leap flag. Any counter can be loaded with a byte through a write port that picks the counter by a three-bit index. A separate combinational read port returns the full byte of any counter, flags included.

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the seconds, minutes and hours bytes read 8'h00 (24-hour mode, meridian flag clear), and the day and month bytes read 8'h01.
- R2: Seconds and minutes count 00 to 59 in packed BCD (tens in bits 7:4, units in bits 3:0); on an advance from 59 the counter goes to 00 and advances the next counter.
- R3: Hours byte layout: bit 7 is the meridian flag (1 = PM), bit 6 is the mode (1 = 12-hour, 0 = 24-hour), bits 5:0 hold the BCD hour. In 24-hour mode the hour runs 00 to 23, and 23 advances to 00 with a carry into the day.
- R4: In 12-hour mode the hour runs 01 to 12; 12 advances to 01, 11 advances to 12 and flips the meridian flag, and only 11 PM to 12 AM carries into the day.
- R5: In 24-hour mode the meridian flag still flips on the 11-to-12 and the 23-to-00 transitions.
- R6: Day of month wraps to 01 after 30 for months 04, 06, 09 and 11 and after 31 for the other non-February months; the month runs 01 to 12, 12 wraps to 01, and the leap flag in bit 7 of the month byte is kept.
- R7: In month 02 the day wraps after 28 when the leap flag is 0 and after 29 when it is 1.
- R8: While run_i is 0, tick_i has no effect and every counter holds its value.
- R9: A write (wr_en_i high) drops a tick in the same cycle, so no counter advances, and the addressed counter takes the written byte as is, with no range check.
- R10: Index map for both ports: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month. The month byte reads with bits 6:5 as 0. Indexes 5 to 7 read 8'h00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Once-per-second advance enable, one cycle wide |
| run_i | input | 1 | 1 lets ticks advance the chain, 0 freezes it |
| wr_en_i | input | 1 | Load strobe for the counter picked by wr_sel_i |
| wr_sel_i | input | 3 | Counter index for the load |
| wr_data_i | input | 8 | Byte to load |
| rd_sel_i | input | 3 | Counter index for the read |
| rd_data_o | output | 8 | Byte of the selected counter |

## Verification
The assertions assume that the counters hold legal BCD values whenever a wrap is checked and that a write and a tick never reach the same counter unnoticed. The wrap properties also take for granted that tick_i lasts one cycle. The bench keeps to these limits. It loads every counter with a legal time before each single tick and drives a write together with a tick only in the one directed priority test. It writes an out-of-range hours byte only after all wrap checks are done, and it rewrites every counter before each vector.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int MON_W  = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_MON  = 3'd4
  } slot_e;

  // one packed-BCD increment, units 9 rolls into tens
  function automatic logic [BYTE_W-1:0] bcd_step(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of a month, BCD month value and leap flag
  function automatic logic [BYTE_W-1:0] last_day(input logic [MON_W-1:0] m,
                                                 input logic leap);
    case (m)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_mod_counter.sv
module bcd_mod_counter
  import cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TOP = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [BYTE_W-1:0] q_o,
  output logic              carry_o
);
  logic [BYTE_W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (ld_i)                q_d = ld_data_i;
    else if (adv_i)          q_d = (q_r == TOP) ? '0 : bcd_step(q_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q_r <= '0;
    else if (ld_i || adv_i)    q_r <= q_d;
  end

  assign q_o     = q_r;
  assign carry_o = adv_i && !ld_i && (q_r == TOP);

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && q_r == TOP) |=> (q_o == 8'h00));
endmodule

// File: rtl/hour_counter.sv
module hour_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [BYTE_W-1:0] q_o,
  output logic              carry_o
);
  logic [BYTE_W-1:0] q_r, q_d;
  logic [5:0]        val, val_inc;
  logic              mode12, pm, flip;

  assign val     = q_r[5:0];
  assign mode12  = q_r[6];
  assign pm      = q_r[7];
  assign val_inc = bcd_step({2'b00, val})[5:0];
  assign flip    = (val == 6'h11) || (!mode12 && val == 6'h23);

  always_comb begin
    q_d = q_r;
    if (ld_i) begin
      q_d = ld_data_i;
    end else if (adv_i) begin
      q_d[7] = pm ^ flip;
      if (mode12) q_d[5:0] = (val == 6'h12) ? 6'h01 : val_inc;
      else        q_d[5:0] = (val == 6'h23) ? 6'h00 : val_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q_r <= '0;
    else if (ld_i || adv_i)    q_r <= q_d;
  end

  assign q_o     = q_r;
  assign carry_o = adv_i && !ld_i &&
                   (mode12 ? (val == 6'h11 && pm) : (val == 6'h23));

  a_r4_noon_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && mode12 && val == 6'h11)
      |=> (q_o[5:0] == 6'h12 && q_o[7] != $past(pm)));
  a_r4_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && mode12 && val == 6'h12) |=> (q_o[5:0] == 6'h01));
  a_r5_flag_in_24h: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && !mode12 && val == 6'h23)
      |=> (q_o[5:0] == 6'h00 && q_o[7] != $past(pm)));
endmodule

// File: rtl/date_counter.sv
module date_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_day_i,
  input  logic              ld_mon_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [BYTE_W-1:0] day_o,
  output logic [BYTE_W-1:0] mon_o
);
  logic [BYTE_W-1:0] day_r, day_d;
  logic [MON_W-1:0]  mon_r, mon_d;
  logic              leap_r, leap_d;
  logic              day_end;

  assign day_end = (day_r == last_day(mon_r, leap_r));

  always_comb begin
    day_d  = day_r;
    mon_d  = mon_r;
    leap_d = leap_r;
    if (ld_day_i)   day_d = ld_data_i;
    else if (adv_i) day_d = day_end ? 8'h01 : bcd_step(day_r);
    if (ld_mon_i) begin
      leap_d = ld_data_i[7];
      mon_d  = ld_data_i[MON_W-1:0];
    end else if (adv_i && day_end) begin
      mon_d = (mon_r == 5'h12) ? 5'h01 : bcd_step({3'b000, mon_r})[MON_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_r  <= 8'h01;
      mon_r  <= 5'h01;
      leap_r <= 1'b0;
    end else begin
      if (ld_day_i || adv_i) day_r <= day_d;
      if (ld_mon_i || adv_i) begin
        mon_r  <= mon_d;
        leap_r <= leap_d;
      end
    end
  end

  assign day_o = day_r;
  assign mon_o = {leap_r, 2'b00, mon_r};

  a_r7_short_feb: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_day_i && !ld_mon_i && mon_r == 5'h02 && !leap_r && day_r == 8'h28)
      |=> (day_o == 8'h01 && mon_o[4:0] == 5'h03));
  a_r6_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_day_i && !ld_mon_i && mon_r == 5'h12 && day_r == 8'h31)
      |=> (mon_o[4:0] == 5'h01 && mon_o[7] == $past(leap_r)));
endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int N_MS = 2;

  logic [1:0]        rst_sync;
  logic              rst_q;
  logic              step;
  logic [N_MS:0]     adv;
  logic [BYTE_W-1:0] ms_q [N_MS];
  logic [BYTE_W-1:0] hour_q, day_q, mon_q;
  logic              hour_carry;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign step   = tick_i && run_i && !wr_en_i;
  assign adv[0] = step;

  for (genvar g = 0; g < N_MS; g++) begin : g_ms
    bcd_mod_counter #(.TOP(8'h59)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_q),
      .adv_i     (adv[g]),
      .ld_i      (wr_en_i && wr_sel_i == SEL_W'(g)),
      .ld_data_i (wr_data_i),
      .q_o       (ms_q[g]),
      .carry_o   (adv[g+1])
    );
  end

  hour_counter u_hour (
    .clk       (clk),
    .rst_n     (rst_q),
    .adv_i     (adv[N_MS]),
    .ld_i      (wr_en_i && wr_sel_i == SEL_HOUR),
    .ld_data_i (wr_data_i),
    .q_o       (hour_q),
    .carry_o   (hour_carry)
  );

  date_counter u_date (
    .clk       (clk),
    .rst_n     (rst_q),
    .adv_i     (hour_carry),
    .ld_day_i  (wr_en_i && wr_sel_i == SEL_DAY),
    .ld_mon_i  (wr_en_i && wr_sel_i == SEL_MON),
    .ld_data_i (wr_data_i),
    .day_o     (day_q),
    .mon_o     (mon_q)
  );

  always_comb begin
    case (rd_sel_i)
      SEL_SEC:  rd_data_o = ms_q[0];
      SEL_MIN:  rd_data_o = ms_q[1];
      SEL_HOUR: rd_data_o = hour_q;
      SEL_DAY:  rd_data_o = day_q;
      SEL_MON:  rd_data_o = mon_q;
      default:  rd_data_o = '0;
    endcase
  end

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_q)
    (!run_i && !wr_en_i) |=> ($stable(ms_q[0]) && $stable(ms_q[1]) &&
                              $stable(hour_q) && $stable(day_q) && $stable(mon_q)));
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en_i && wr_sel_i == SEL_SEC) |=> (ms_q[0] == $past(wr_data_i) && $stable(ms_q[1])));
endmodule

// File: tb/bcd_calendar_chain_test.sv
module bcd_calendar_chain_test;
  logic       clk = 1'b0;
  logic       rst_n, tick_i, run_i, wr_en_i;
  logic [2:0] wr_sel_i, rd_sel_i;
  logic [7:0] wr_data_i, rd_data_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  bcd_calendar_chain uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
  );

  // {req, preset sec,min,hour,day,mon, expected sec,min,hour,day,mon}
  localparam int NV = 16;
  localparam logic [87:0] VEC [NV] = '{
    {8'd2, 40'h00_00_00_01_01, 40'h01_00_00_01_01},  // R2 plain second
    {8'd2, 40'h59_00_00_01_01, 40'h00_01_00_01_01},  // R2 seconds wrap
    {8'd2, 40'h59_59_00_01_01, 40'h00_00_01_01_01},  // R2 minutes wrap
    {8'd3, 40'h59_59_A3_15_01, 40'h00_00_00_16_01},  // R3 23 -> 00, day carry
    {8'd5, 40'h59_59_11_10_01, 40'h00_00_92_10_01},  // R5 24h flag flips at 12
    {8'd4, 40'h59_59_51_10_01, 40'h00_00_D2_10_01},  // R4 11 AM -> 12 PM
    {8'd4, 40'h59_59_D1_10_01, 40'h00_00_52_11_01},  // R4 11 PM -> 12 AM, day
    {8'd4, 40'h59_59_52_10_01, 40'h00_00_41_10_01},  // R4 12 -> 01
    {8'd6, 40'h59_59_A3_30_04, 40'h00_00_00_01_05},  // R6 30-day month
    {8'd6, 40'h59_59_A3_30_05, 40'h00_00_00_31_05},  // R6 31-day month
    {8'd6, 40'h59_59_A3_31_12, 40'h00_00_00_01_01},  // R6 year wrap
    {8'd6, 40'h59_59_A3_31_92, 40'h00_00_00_01_81},  // R6 leap flag kept
    {8'd6, 40'h59_59_A3_30_11, 40'h00_00_00_01_12},  // R6 November
    {8'd7, 40'h59_59_A3_28_02, 40'h00_00_00_01_03},  // R7 Feb 28 no leap
    {8'd7, 40'h59_59_A3_28_82, 40'h00_00_00_29_82},  // R7 Feb 28 leap
    {8'd7, 40'h59_59_A3_29_82, 40'h00_00_00_01_83}   // R7 Feb 29 leap
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    rd_sel_i = sel;
    #1 d = rd_data_o;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; tick_i = 1'b0; run_i = 1'b0; wr_en_i = 1'b0;
    wr_sel_i = '0; wr_data_i = '0; rd_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd(3'd0, v); chk("R1 sec",   v, 8'h00);
    rd(3'd1, v); chk("R1 min",   v, 8'h00);
    rd(3'd2, v); chk("R1 hour",  v, 8'h00);
    rd(3'd3, v); chk("R1 day",   v, 8'h01);
    rd(3'd4, v); chk("R1 month", v, 8'h01);

    run_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][87:80], i);
      for (int k = 0; k < 5; k++) wr(3'(k), VEC[i][79-8*k -: 8]);
      pulse_tick();
      for (int k = 0; k < 5; k++) begin
        rd(3'(k), v);
        chk(tag, v, VEC[i][39-8*k -: 8]);
      end
    end

    // R8 stopped chain ignores ticks
    wr(3'd0, 8'h20);
    run_i = 1'b0;
    pulse_tick();
    rd(3'd0, v); chk("R8 sec held", v, 8'h20);
    run_i = 1'b1;

    // R10 unused indexes and month masking
    wr(3'd5, 8'hAA);
    rd(3'd5, v); chk("R10 idx5", v, 8'h00);
    rd(3'd7, v); chk("R10 idx7", v, 8'h00);
    rd(3'd0, v); chk("R10 sec untouched", v, 8'h20);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R10 month mask", v, 8'h9F);

    // R9 write beats a coincident tick
    wr(3'd0, 8'h59);
    wr(3'd1, 8'h05);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h30;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd(3'd0, v); chk("R9 loaded sec", v, 8'h30);
    rd(3'd1, v); chk("R9 min no carry", v, 8'h05);
    wr(3'd2, 8'h7F);
    rd(3'd2, v); chk("R9 unchecked hour", v, 8'h7F);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule